// File: doc/BRIEF.md
# Two-Level Interrupt Request Controller

This block collects level-sensitive, active-high interrupt sources and drives two processor request lines. A one-bit controller feeds the fast request line. A 32-bit controller feeds the general request line. Software reads each controller through a plain synchronous register port. It can see the unmasked inputs and the inputs after masking. It changes the enable mask with write-one-to-set and write-one-to-clear registers.

The general controller maps its sources as follows:
- bit 0 is an ordinary input, so it can be tied to the same source as the fast controller;
- bit 1 is a software-programmed interrupt, driven only by a set/clear register pair;
- bits 2 and 3 are communications receive and transmit;
- bits 4 and 5 are timer 1 and timer 2;
- bits 6 to 31 are free external inputs.

The bit-1 register lets a handler pass a fast event down to the general level. The hardware does no prioritisation, no vectoring and no latching. Software reads the masked status and decides what to do.

Word addresses:

| Address | Register |
|---|---|
| 0 | fast raw |
| 1 | fast masked |
| 2 | fast enable set, reads the enable mask |
| 3 | fast enable clear |
| 8 | general raw |
| 9 | general masked |
| 10 | general enable set, reads the enable mask |
| 11 | general enable clear |
| 12 | software-interrupt set, reads the software bit at bit 1 |
| 13 | software-interrupt clear |

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset both enable masks and the software bit are 0. `fiq_o`, `irq_o` and `rdata_o` are 0.
- R2: `fiq_o` in each cycle equals `fiq_src_i` AND the fast enable bit, as sampled at the previous clock edge.
- R3: `irq_o` in each cycle equals the OR of all general masked bits, as sampled at the previous clock edge.
- R4: Writing to an enable-set address (2 or 10) sets every enable bit whose write-data bit is 1 and leaves the other bits unchanged. Reading that address returns the enable mask.
- R5: Writing to an enable-clear address (3 or 11) clears every enable bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: The raw view (address 0 or 8) shows the current input levels, with no latching. A source that drops reads as 0.
- R7: The masked view (address 1 or 9) returns the raw view AND the enable mask.
- R8: General bit 1 is the software bit. Writing data bit 1 = 1 to address 12 sets it, and to address 13 clears it. Address 12 reads it back at bit 1. Input `irq_src_i[1]` has no effect.
- R9: General bit 0 is an ordinary input with its own enable. It can mirror the fast source, and the two enables act independently.
- R10: Reads of unused addresses (4–7, 14, 15) return 0. Writes to read-only or unused addresses change no state.
- R11: `rdata_o` is registered. It presents the register selected by `addr_i` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| fiq_src_i | input | 1 | Fast interrupt source, level, active high |
| irq_src_i | input | 32 | General interrupt sources, level, active high (bit 1 ignored) |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 32→1 | General interrupt request |

## Verification
The assertions check on every cycle that:
- set and clear writes touch exactly the bits written as 1;
- writes to read-only addresses leave the mask untouched;
- each request output follows its masked status with a single cycle of lag;
- the software bit follows its set and clear writes;
- unused addresses read as zero.

Only the bench scenarios can show the following:
- a dropped source reads as 0 rather than staying latched;
- input bit 1 is ignored;
- the fast source and general bit 0 can be mirrored and still disabled independently;
- the read values at every address match under long random traffic.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int FAST_W   = 1;
  localparam int GEN_W    = 32;

  // bank bases (word addresses)
  localparam int FAST_BASE = 0;
  localparam int GEN_BASE  = 8;

  // offsets inside a bank
  localparam int OFF_RAW  = 0;
  localparam int OFF_MSK  = 1;
  localparam int OFF_ESET = 2;
  localparam int OFF_ECLR = 3;
  localparam int OFF_SSET = 4;
  localparam int OFF_SCLR = 5;

  // general source map
  localparam int GEN_BIT_MIRROR = 0;
  localparam int GEN_BIT_SOFT   = 1;
  localparam int GEN_BIT_COM_RX = 2;
  localparam int GEN_BIT_COM_TX = 3;
  localparam int GEN_BIT_TMR1   = 4;
  localparam int GEN_BIT_TMR2   = 5;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctrl_pkg::*;
#(
  parameter int W        = 32,
  parameter int AW       = 4,
  parameter int BASE     = 8,
  parameter bit HAS_SOFT = 1'b1,
  parameter int SOFT_BIT = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  src_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic          rd_hit_o,
  output logic [W-1:0]  rd_data_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_RAW  = AW'(BASE + OFF_RAW);
  localparam logic [AW-1:0] A_MSK  = AW'(BASE + OFF_MSK);
  localparam logic [AW-1:0] A_ESET = AW'(BASE + OFF_ESET);
  localparam logic [AW-1:0] A_ECLR = AW'(BASE + OFF_ECLR);
  localparam logic [AW-1:0] A_SSET = AW'(BASE + OFF_SSET);
  localparam logic [AW-1:0] A_SCLR = AW'(BASE + OFF_SCLR);

  logic [W-1:0] en_q;
  logic [W-1:0] raw;
  logic [W-1:0] masked;
  logic [W-1:0] soft_vec;
  logic         soft_q;
  logic         irq_q;

  // enable mask: separate set and clear addresses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (we_i && addr_i == A_ESET) begin
      en_q <= en_q | wdata_i;
    end else if (we_i && addr_i == A_ECLR) begin
      en_q <= en_q & ~wdata_i;
    end
  end

  generate
    if (HAS_SOFT) begin : g_soft
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          soft_q <= 1'b0;
        end else if (we_i && addr_i == A_SSET && wdata_i[SOFT_BIT]) begin
          soft_q <= 1'b1;
        end else if (we_i && addr_i == A_SCLR && wdata_i[SOFT_BIT]) begin
          soft_q <= 1'b0;
        end
      end

      p_soft_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_SSET && wdata_i[SOFT_BIT]) |=> soft_q);
      p_soft_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_SCLR && wdata_i[SOFT_BIT]) |=> !soft_q);
    end else begin : g_nosoft
      assign soft_q = 1'b0;
    end
  endgenerate

  // raw view: live levels, soft bit replaces its input
  always_comb begin
    raw = src_i;
    if (HAS_SOFT) raw[SOFT_BIT] = soft_q;
  end

  assign masked = raw & en_q;

  always_comb begin
    soft_vec = '0;
    soft_vec[SOFT_BIT] = soft_q;
  end

  always_comb begin
    rd_hit_o  = 1'b1;
    rd_data_o = '0;
    if (addr_i == A_RAW)                   rd_data_o = raw;
    else if (addr_i == A_MSK)              rd_data_o = masked;
    else if (addr_i == A_ESET)             rd_data_o = en_q;
    else if (addr_i == A_ECLR)             rd_data_o = '0;
    else if (HAS_SOFT && addr_i == A_SSET) rd_data_o = soft_vec;
    else if (HAS_SOFT && addr_i == A_SCLR) rd_data_o = '0;
    else                                   rd_hit_o  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked;
  end

  assign irq_o = irq_q;

  p_en_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ESET) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
  p_en_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ECLR) |=> ((en_q & $past(wdata_i)) == '0));
  p_ro_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_RAW || addr_i == A_MSK)) |=> $stable(en_q));
  // R2 for the fast bank, R3 for the general bank
  p_out_lag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(raw & en_q))));
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port #(
  parameter int DW = 32,
  parameter int FW = 1,
  parameter int GW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_hit_i,
  input  logic [FW-1:0] fast_data_i,
  input  logic          gen_hit_i,
  input  logic [GW-1:0] gen_data_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rd_d;
  logic [DW-1:0] rd_q;

  always_comb begin
    rd_d = '0;
    if (fast_hit_i)     rd_d = DW'(fast_data_i);
    else if (gen_hit_i) rd_d = DW'(gen_data_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rdata_o = rd_q;

  p_unused_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_hit_i && !gen_hit_i) |=> (rdata_o == '0));
  p_no_double_hit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fast_hit_i && gen_hit_i));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              fiq_src_i,
  input  logic [GEN_W-1:0]  irq_src_i,
  output logic              fiq_o,
  output logic              irq_o
);
  logic              fast_hit;
  logic [FAST_W-1:0] fast_rd;
  logic              gen_hit;
  logic [GEN_W-1:0]  gen_rd;

  irq_bank #(
    .W(FAST_W), .AW(ADDR_W), .BASE(FAST_BASE), .HAS_SOFT(1'b0), .SOFT_BIT(0)
  ) u_fast (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(fiq_src_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i[FAST_W-1:0]),
    .rd_hit_o(fast_hit), .rd_data_o(fast_rd), .irq_o(fiq_o)
  );

  irq_bank #(
    .W(GEN_W), .AW(ADDR_W), .BASE(GEN_BASE), .HAS_SOFT(1'b1), .SOFT_BIT(GEN_BIT_SOFT)
  ) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(irq_src_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i[GEN_W-1:0]),
    .rd_hit_o(gen_hit), .rd_data_o(gen_rd), .irq_o(irq_o)
  );

  irq_rd_port #(.DW(DATA_W), .FW(FAST_W), .GW(GEN_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fast_hit_i(fast_hit), .fast_data_i(fast_rd),
    .gen_hit_i(gen_hit), .gen_data_i(gen_rd),
    .rdata_o(rdata_o)
  );
endmodule

// File: tb/tb_irq_ctrl_top.sv
module tb_irq_ctrl_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        fiq_src_i = 1'b0;
  logic [31:0] irq_src_i = '0;
  logic        fiq_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  irq_ctrl_top dut (.*);

  // reference model
  bit          m_en_f;
  bit [31:0]   m_en_g;
  bit          m_soft;
  bit          m_live;
  bit          x_fiq, x_irq;
  bit [31:0]   x_rd;

  function automatic bit [31:0] m_read(input bit [3:0] a, input bit fs, input bit [31:0] gs,
                                       input bit ef, input bit [31:0] eg, input bit sf);
    bit [31:0] graw;
    graw = gs;
    graw[1] = sf;
    case (a)
      4'd0:  return {31'd0, fs};
      4'd1:  return {31'd0, fs & ef};
      4'd2:  return {31'd0, ef};
      4'd8:  return graw;
      4'd9:  return graw & eg;
      4'd10: return eg;
      4'd12: return {30'd0, sf, 1'b0};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en_f = 0; m_en_g = '0; m_soft = 0; m_live = 0;
      x_fiq = 0; x_irq = 0; x_rd = '0;
    end else begin
      bit [31:0] graw;
      graw = irq_src_i;
      graw[1] = m_soft;
      x_fiq = fiq_src_i & m_en_f;
      x_irq = |(graw & m_en_g);
      x_rd  = m_read(addr_i, fiq_src_i, irq_src_i, m_en_f, m_en_g, m_soft);
      if (we_i) begin
        case (addr_i)
          4'd2:  m_en_f = m_en_f | wdata_i[0];
          4'd3:  m_en_f = m_en_f & ~wdata_i[0];
          4'd10: m_en_g = m_en_g | wdata_i;
          4'd11: m_en_g = m_en_g & ~wdata_i;
          4'd12: if (wdata_i[1]) m_soft = 1;
          4'd13: if (wdata_i[1]) m_soft = 0;
          default: ;
        endcase
      end
      m_live = 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && m_live) begin
      check("R2 fiq_o model", {31'd0, fiq_o}, {31'd0, x_fiq});
      check("R3 irq_o model", {31'd0, irq_o}, {31'd0, x_irq});
      check("R11 rdata model", rdata_o, x_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr_i = a; we_i = 1'b0;
    @(negedge clk_i);
    check(tag, rdata_o, exp);
  endtask

  task automatic outs(input bit ef, input bit ei, input string tag);
    addr_i = 4'd15;
    @(negedge clk_i);
    check(tag, {30'd0, fiq_o, irq_o}, {30'd0, ef, ei});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset outputs", {fiq_o, irq_o, rdata_o[29:0]}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    outs(0, 0, "R1 outputs after reset");
    rd(4'd10, 32'h0, "R1 general enable zero");
    rd(4'd12, 32'h0, "R1 soft bit zero");
    rd(4'd2,  32'h0, "R1 fast enable zero");

    // enable set/clear
    wr(4'd10, 32'h30);  rd(4'd10, 32'h30, "R4 set bits");
    wr(4'd10, 32'h01);  rd(4'd10, 32'h31, "R4 zeros leave bits");
    wr(4'd11, 32'h10);  rd(4'd10, 32'h21, "R5 clear bit");
    wr(4'd11, 32'h00);  rd(4'd10, 32'h21, "R5 zero clear no effect");

    // raw / masked, level behaviour
    irq_src_i = 32'h20;
    rd(4'd8, 32'h20, "R6 raw");
    rd(4'd9, 32'h20, "R7 masked");
    outs(0, 1, "R3 irq asserted");
    irq_src_i = 32'h60;
    rd(4'd8, 32'h60, "R6 raw two bits");
    rd(4'd9, 32'h20, "R7 masked filters");
    irq_src_i = 32'h40;
    rd(4'd9, 32'h0,  "R7 masked none");
    outs(0, 0, "R3 irq drops with source");
    irq_src_i = 32'h0;
    rd(4'd8, 32'h0,  "R6 no latching");

    // software bit
    irq_src_i = 32'h2;
    rd(4'd8, 32'h0, "R8 input bit1 ignored");
    wr(4'd12, 32'h2);
    rd(4'd12, 32'h2, "R8 soft readback");
    rd(4'd8, 32'h2,  "R8 soft in raw");
    outs(0, 0, "R3 soft masked off");
    wr(4'd10, 32'h2);
    outs(0, 1, "R8 soft raises irq");
    wr(4'd13, 32'h2);
    rd(4'd12, 32'h0, "R8 soft cleared");
    outs(0, 0, "R8 irq drops after soft clear");
    irq_src_i = 32'h0;

    // fast controller and mirror bit
    fiq_src_i = 1'b1;
    outs(0, 0, "R2 fast disabled");
    rd(4'd0, 32'h1, "R6 fast raw");
    rd(4'd1, 32'h0, "R7 fast masked off");
    wr(4'd2, 32'h1);
    rd(4'd2, 32'h1, "R4 fast enable");
    outs(1, 0, "R2 fast asserted");
    irq_src_i = 32'h1;
    outs(1, 1, "R9 mirrored on both lines");
    wr(4'd3, 32'h1);
    outs(0, 1, "R9 fast off general stays");
    rd(4'd2, 32'h0, "R5 fast enable cleared");
    fiq_src_i = 1'b0;
    irq_src_i = 32'h0;

    // unused and read-only addresses
    irq_src_i = 32'hFFFF_FFFF;
    fiq_src_i = 1'b1;
    rd(4'd4, 32'h0, "R10 unused 4");
    rd(4'd5, 32'h0, "R10 unused 5");
    rd(4'd6, 32'h0, "R10 unused 6");
    rd(4'd14, 32'h0, "R10 unused 14");
    rd(4'd15, 32'h0, "R10 unused 15");
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd10, 32'h23, "R10 raw write ignored");
    wr(4'd9, 32'h0);
    rd(4'd10, 32'h23, "R10 masked write ignored");
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd2, 32'h0, "R10 unused write fast");
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd12, 32'h0, "R10 unused write soft");
    wr(4'd0, 32'h1);
    rd(4'd2, 32'h0, "R10 fast raw write ignored");
    irq_src_i = 32'h0;
    fiq_src_i = 1'b0;

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      addr_i    = 4'($urandom);
      we_i      = ($urandom % 4) == 0;
      wdata_i   = $urandom;
      irq_src_i = ($urandom % 2) ? $urandom : 32'h0;
      fiq_src_i = 1'($urandom);
      @(negedge clk_i);
    end
    we_i = 1'b0;
    @(negedge clk_i);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule